// File: doc/BRIEF.md
# Receive Staging FIFO with Head-Arrival Events

This block queues bytes handed over by a serial receiver and copies them, one per accepted write, into a bounded memory buffer whose base address and length are set by a start command. A write is offered only while the transfer is running, a byte sits at the queue head and the buffer still has room. Once the buffer is full, the head byte is retained in the queue and later bytes pile up behind it. They stay there until a new start command moves draining to a fresh buffer, or until a flush discards them.

The data-ready event is tied to the queue head, not to the receive line. A pulse is raised whenever a different byte becomes the head entry. After the buffer fills, bytes that arrive behind a retained head produce no pulse until they move up. The number of pulses therefore does not have to match the written-byte count, which counts only completed memory writes.

The receive input is a plain valid strobe with no back-pressure, because the line cannot be paused. A byte that finds the queue full is dropped. The memory side is a valid/ready stream. While `mem_valid` is high and `mem_ready` is low, the offer stays in place with the same address and data. One byte is consumed on each cycle in which both are high.

Top module: `rx_stage_fifo`

## Requirements
- R1: After reset, `mem_valid`, `rdy_evt`, `end_evt`, `overrun` and `flush_done` are 0, and `amount` is 0.
- R2: A byte accepted while the queue is empty makes `rdy_evt` high for exactly the one cycle that follows its strobe. This also holds when the buffer is already full.
- R3: When a write completes and another byte is queued behind the head (or arrives in that cycle), that byte becomes the head and `rdy_evt` pulses in the next cycle.
- R4: `mem_valid` is high exactly when the transfer is running, no start, stop or flush is asserted, the queue holds a byte and `amount` is below the maximum. `mem_addr` equals base plus `amount`, and `mem_data` equals the head byte. The head advances only on a cycle with `mem_valid` and `mem_ready` both high; until then address and data hold.
- R5: `amount` rises by one per completed write and never exceeds the maximum. At the maximum, the head byte is retained and is not written.
- R6: Bytes that arrive while a retained head occupies the queue are queued without raising `rdy_evt`.
- R7: `end_evt` pulses for one cycle, in the same cycle in which `amount` first shows the maximum.
- R8: `start` loads a new base and maximum, clears `amount` to 0 and runs the transfer. A retained head is then written first, and no new `rdy_evt` is raised for it.
- R9: `flush` empties the queue with no memory write. The next cycle shows `flush_done` high and `flush_count` equal to the number of bytes discarded, and `overrun` is cleared. A byte strobed in the flush cycle is ignored.
- R10: A byte strobed while the queue holds DEPTH (default 4) bytes is dropped, and `overrun` is set and stays set until a flush.
- R11: `stop` ends the transfer: no further writes are offered, while bytes are still queued and head events are still raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Received byte strobe |
| in_data | input | 8 | Received byte |
| start | input | 1 | Start a transfer into a new buffer |
| start_base | input | AW | Buffer base address loaded by start |
| start_max | input | CW | Buffer length in bytes loaded by start |
| stop | input | 1 | End the current transfer |
| flush | input | 1 | Discard all queued bytes |
| mem_valid | output | 1 | Write offer |
| mem_ready | input | 1 | Memory accepts the offered write |
| mem_addr | output | AW | Write address |
| mem_data | output | 8 | Write byte (queue head) |
| rdy_evt | output | 1 | One-cycle pulse when a new byte becomes the head |
| end_evt | output | 1 | One-cycle pulse when the buffer fills |
| amount | output | CW | Bytes written in the current transfer |
| overrun | output | 1 | Sticky dropped-byte flag |
| flush_done | output | 1 | Pulse the cycle after a flush |
| flush_count | output | CNTW | Bytes discarded by the last flush |

## Verification
The tests start with isolated bytes into an empty queue with the memory always ready, which separates head events from write completions. Next, a burst is sent while `mem_ready` is held low, so the events must follow the head instead of the arrivals and the offered address and data must hold. Bytes are then sent past the buffer maximum and past the queue depth, which makes the event count and `amount` differ and triggers the overrun. Finally, restart, stop and flush are exercised on a retained head, and a streaming run with a periodic ready pattern mixes simultaneous arrival and drain.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/rxs_queue.sv
module rxs_queue
  import rxs_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  byte_t           push_data,
  input  logic            pop,
  input  logic            clear,
  output byte_t           head,
  output logic [CNTW-1:0] fill
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  byte_t         slot_q [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !clear) slot_q[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= step_ptr(wr_ptr);
      if (pop)  rd_ptr <= step_ptr(rd_ptr);
      fill <= fill + CNTW'(push) - CNTW'(pop);
    end
  end

  assign head = slot_q[rd_ptr];
endmodule

// File: rtl/rxs_drain.sv
module rxs_drain #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_base,
  input  logic [CW-1:0] start_max,
  input  logic          stop,
  input  logic          flush,
  input  logic          have_byte,
  input  logic          mem_ready,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic          fire,
  output logic [CW-1:0] amount,
  output logic [CW-1:0] cur_max,
  output logic          end_evt
);
  logic          running;
  logic [AW-1:0] base_q;
  logic          room;

  assign room      = amount < cur_max;
  assign mem_valid = running && !start && !stop && !flush && have_byte && room;
  assign fire      = mem_valid && mem_ready;
  assign mem_addr  = base_q + AW'(amount);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      base_q  <= '0;
      cur_max <= '0;
      amount  <= '0;
      end_evt <= 1'b0;
    end else begin
      end_evt <= fire && ((amount + CW'(1)) == cur_max);
      if (start) begin
        running <= 1'b1;
        base_q  <= start_base;
        cur_max <= start_max;
        amount  <= '0;
      end else begin
        if (stop) running <= 1'b0;
        if (fire) amount <= amount + CW'(1);
      end
    end
  end
endmodule

// File: rtl/rx_stage_fifo.sv
module rx_stage_fifo
  import rxs_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int CW    = 8,
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [7:0]      in_data,
  input  logic            start,
  input  logic [AW-1:0]   start_base,
  input  logic [CW-1:0]   start_max,
  input  logic            stop,
  input  logic            flush,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic [AW-1:0]   mem_addr,
  output logic [7:0]      mem_data,
  output logic            rdy_evt,
  output logic            end_evt,
  output logic [CW-1:0]   amount,
  output logic            overrun,
  output logic            flush_done,
  output logic [CNTW-1:0] flush_count
);
  localparam logic [CNTW-1:0] FULL_AT = CNTW'(DEPTH);

  logic [CNTW-1:0] fill;
  logic [CW-1:0]   cur_max;
  byte_t           head;
  logic            full, push, fire, evt_d;

  assign full = fill == FULL_AT;
  assign push = in_valid && !flush && !full;

  rxs_queue #(.DEPTH(DEPTH), .CNTW(CNTW)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (in_data),
    .pop       (fire),
    .clear     (flush),
    .head      (head),
    .fill      (fill)
  );

  rxs_drain #(.AW(AW), .CW(CW)) u_drain (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_base (start_base),
    .start_max  (start_max),
    .stop       (stop),
    .flush      (flush),
    .have_byte  (fill != '0),
    .mem_ready  (mem_ready),
    .mem_valid  (mem_valid),
    .mem_addr   (mem_addr),
    .fire       (fire),
    .amount     (amount),
    .cur_max    (cur_max),
    .end_evt    (end_evt)
  );

  assign mem_data = head;

  // A new head appears when an empty queue takes a byte, or when a write
  // retires the head and another byte stands (or lands) behind it.
  assign evt_d = !flush &&
                 ((fill == '0 && push) ||
                  (fire && (fill > CNTW'(1) || push)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_evt     <= 1'b0;
      overrun     <= 1'b0;
      flush_done  <= 1'b0;
      flush_count <= '0;
    end else begin
      rdy_evt    <= evt_d;
      flush_done <= flush;
      if (flush) begin
        flush_count <= fill;
        overrun     <= 1'b0;
      end else if (in_valid && full) begin
        overrun <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_stage_fifo_chk.sv
module rx_stage_fifo_chk #(
  parameter int AW   = 16,
  parameter int CW   = 8,
  parameter int CNTW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            stop,
  input logic            flush,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic [AW-1:0]   mem_addr,
  input logic [7:0]      mem_data,
  input logic            rdy_evt,
  input logic            end_evt,
  input logic [CW-1:0]   amount,
  input logic [CW-1:0]   cur_max,
  input logic            overrun,
  input logic            flush_done,
  input logic [CNTW-1:0] fill
);
  a_r4_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      ((mem_valid || start || stop || flush) && $stable(mem_addr) && $stable(mem_data)));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    amount <= cur_max);

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> (amount == $past(amount) + CW'(1)));

  a_r7_end_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |-> (amount == cur_max && $past(mem_valid && mem_ready)));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !flush) |=> overrun);

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill == '0 && flush_done && !rdy_evt));

  a_r2_evt_has_head: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_evt |-> (fill != '0));
endmodule

bind rx_stage_fifo rx_stage_fifo_chk #(.AW(AW), .CW(CW), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .flush(flush),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_data(mem_data), .rdy_evt(rdy_evt), .end_evt(end_evt), .amount(amount),
  .cur_max(cur_max), .overrun(overrun), .flush_done(flush_done), .fill(fill)
);

// File: tb/rx_stage_fifo_bench.sv
module rx_stage_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic start = 1'b0;
  logic [AW-1:0] start_base = '0;
  logic [CW-1:0] start_max = '0;
  logic stop = 1'b0;
  logic flush = 1'b0;
  logic mem_ready = 1'b0;
  logic mem_valid, rdy_evt, end_evt, overrun, flush_done;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_data;
  logic [CW-1:0] amount;
  logic [CNTW-1:0] flush_count;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_stage_fifo #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_rx_stage_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .start(start), .start_base(start_base), .start_max(start_max),
    .stop(stop), .flush(flush), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .rdy_evt(rdy_evt),
    .end_evt(end_evt), .amount(amount), .overrun(overrun),
    .flush_done(flush_done), .flush_count(flush_count)
  );

  int checks = 0;
  int errors = 0;
  int evcount = 0;
  bit done = 1'b0;

  // Behavioural reference state
  logic [7:0] q[$];
  int  m_amt = 0, m_max = 0, m_base = 0, m_fcnt = 0;
  bit  m_run = 0, m_evt = 0, m_end = 0, m_ovr = 0, m_fdone = 0;

  task automatic chk(input longint act, input longint exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit offer();
    return m_run && !start && !stop && !flush && q.size() > 0 && m_amt < m_max;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_amt = 0; m_max = 0; m_base = 0; m_fcnt = 0;
      m_run = 0; m_evt = 0; m_end = 0; m_ovr = 0; m_fdone = 0;
    end else begin
      int  n;
      bit  fire, take;
      n    = q.size();
      fire = offer() && mem_ready;
      take = in_valid && !flush && n < DEPTH;
      m_evt = !flush && ((n == 0 && take) || (fire && (n > 1 || take)));
      m_end = fire && (m_amt + 1 == m_max);
      m_fdone = flush;
      if (flush) begin
        m_fcnt = n;
        m_ovr  = 0;
        q.delete();
      end else begin
        if (in_valid && n == DEPTH) m_ovr = 1;
        if (fire) void'(q.pop_front());
        if (take) q.push_back(in_data);
      end
      if (start) begin
        m_run = 1; m_amt = 0; m_max = int'(start_max); m_base = int'(start_base);
      end else begin
        if (stop) m_run = 0;
        if (fire) m_amt++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit v;
      v = offer();
      chk(mem_valid, v, "R4 mem_valid");
      if (v) begin
        chk(mem_addr, (m_base + m_amt) & 16'hFFFF, "R4 mem_addr");
        chk(mem_data, q[0], "R4 mem_data");
      end
      chk(rdy_evt, m_evt, "R2/R3 rdy_evt");
      chk(end_evt, m_end, "R7 end_evt");
      chk(amount, m_amt, "R5 amount");
      chk(overrun, m_ovr, "R10 overrun");
      chk(flush_done, m_fdone, "R9 flush_done");
      chk(flush_count, m_fcnt, "R9 flush_count");
      if (rdy_evt) evcount++;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic byte_in(input logic [7:0] d);
    in_valid = 1'b1;
    in_data  = d;
    step();
    in_valid = 1'b0;
  endtask

  task automatic do_start(input int base, input int mx);
    start = 1'b1;
    start_base = AW'(base);
    start_max = CW'(mx);
    step();
    start = 1'b0;
    #1;
  endtask

  initial begin
    int ev0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk(mem_valid, 0, "R1 mem_valid");
    chk(amount, 0, "R1 amount");
    chk(rdy_evt, 0, "R1 rdy_evt");
    chk(overrun, 0, "R1 overrun");

    // Isolated bytes, memory always ready
    do_start(16'h0100, 3);
    mem_ready = 1'b1;
    byte_in(8'hA1);
    chk(rdy_evt, 1, "R2 event after arrival into empty queue");
    step();
    chk(amount, 1, "R5 first write counted");

    // Burst under back-pressure
    mem_ready = 1'b0;
    byte_in(8'hA2);
    byte_in(8'hA3);
    step();
    chk(mem_data, 8'hA2, "R4 data held under back-pressure");
    chk(mem_addr, 16'h0101, "R4 address held under back-pressure");
    mem_ready = 1'b1;
    repeat (4) step();
    chk(amount, 3, "R5 amount at maximum");

    // Beyond the maximum: retained head, silent queueing, overrun
    ev0 = evcount;
    byte_in(8'hB1);
    chk(rdy_evt, 1, "R2 event for byte reaching empty head after fill");
    byte_in(8'hB2);
    byte_in(8'hB3);
    byte_in(8'hB4);
    step();
    chk(evcount - ev0, 1, "R6 no events behind retained head");
    chk(mem_valid, 0, "R5 head retained at maximum");
    byte_in(8'hB5);
    step();
    chk(overrun, 1, "R10 overrun on full queue");

    // Restart drains retained head without a fresh event
    mem_ready = 1'b0;
    do_start(16'h0200, 8);
    chk(rdy_evt, 0, "R8 no event for retained head");
    chk(mem_valid, 1, "R8 retained head offered");
    chk(mem_data, 8'hB1, "R8 retained head data");
    chk(mem_addr, 16'h0200, "R8 new base");
    mem_ready = 1'b1;
    repeat (6) step();
    chk(amount, 4, "R8 four bytes written to new buffer");

    // Stop: queueing and events continue, writes do not
    stop = 1'b1;
    step();
    stop = 1'b0;
    byte_in(8'hC1);
    chk(rdy_evt, 1, "R11 event while stopped");
    byte_in(8'hC2);
    step();
    chk(mem_valid, 0, "R11 no offer after stop");

    // Flush discards
    flush = 1'b1;
    in_valid = 1'b1;
    in_data = 8'hEE;
    step();
    flush = 1'b0;
    in_valid = 1'b0;
    chk(flush_count, 2, "R9 discarded count");
    chk(flush_done, 1, "R9 flush_done pulse");
    chk(overrun, 0, "R9 overrun cleared");
    step();
    chk(rdy_evt, 0, "R9 byte during flush ignored");

    // Streaming with periodic ready
    do_start(16'h0300, 5);
    for (int i = 0; i < 12; i++) begin
      mem_ready = (i % 3) != 2;
      in_valid  = (i < 7);
      in_data   = 8'(8'h40 + i);
      step();
    end
    in_valid = 1'b0;
    mem_ready = 1'b1;
    repeat (5) step();
    chk(amount, 5, "R7 stream reaches maximum");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule